// File: doc/BRIEF.md
# SPI Status Flag Controller

This block keeps the three status flags of a byte-wide serial peripheral interface and handles the CPU register accesses that read and clear them. The three flags are "receive byte ready", "transmit holding register empty" and "master mode fault". The serial shift engine is not part of the block. It is represented by two one-cycle strobes: one says a byte has arrived, and the other says the transmit holding byte has been taken for shifting.

The CPU sees three register addresses: a read-only status register, a data register and a control register. A read of the data register returns the last received byte. A write to the data register loads the transmit holding register. No flag can be cleared by a single access. The CPU must first read the status register and see the flag at 1. That read arms the flag. The flag then clears on one specific later access. A data write made without that arming is dropped. An interrupt request output stays high while any flag is set.

Top module: `spi_flag_ctrl`

## Requirements
- R1: A status read returns the receive-ready flag in bit 7, the transmit-empty flag in bit 5 and the mode-fault flag in bit 4. Bits 6 and 3..0 read 0.
- R2: A write to the status address changes no flag, no arming and not the transmit holding byte.
- R3: A receive strobe stores the received byte and sets the receive-ready flag from the next cycle on. A data read returns the stored byte in the same cycle.
- R4: The receive-ready flag clears only on a data read that follows a status read which returned it as 1. An unarmed data read leaves it set.
- R5: An armed data write (one that follows a status read returning transmit-empty as 1) loads the byte onto `tx_byte` and clears transmit-empty from the next cycle on.
- R6: An unarmed data write is dropped. `tx_byte` and transmit-empty keep their values.
- R7: When the input sampled at a clock edge shows slave select low while master mode and fault detection are both enabled, the mode-fault flag is set from the next cycle on. If either enable is 0, the flag is not set.
- R8: The mode-fault flag clears only on a control-register write that follows a status read which returned it as 1.
- R9: After reset, receive-ready is 0, mode-fault is 0, transmit-empty is 1, `tx_byte` is 0 and no flag is armed.
- R10: Each flag is armed separately. Its arming survives accesses to other registers and is used up by the one matching access.
- R11: The take strobe sets transmit-empty again. When a set event and the clearing access of the same flag fall in one cycle, the flag stays set (an armed data write still loads its byte).
- R12: `irq` is 1 exactly while at least one of the three flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address (control 0, status 3, data 5 by default) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_byte_valid | input | 1 | One-cycle strobe: a received byte is ready |
| rx_byte | input | 8 | Received byte |
| tx_taken | input | 1 | One-cycle strobe: the holding byte was taken for shifting |
| tx_byte | output | 8 | Transmit holding byte |
| ss_n | input | 1 | Slave-select pin level, low active |
| master_en | input | 1 | Block is configured as master |
| fault_det_en | input | 1 | Mode-fault detection enabled |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check several things. Each set event, whether a strobe or a fault, makes its flag appear one cycle later. A set flag survives every cycle that is not its own clearing access. An unarmed data write never moves `tx_byte`. The reserved status bits read as zero. Only the bench scenarios can show the clearing sequences from start to end. These include the arming that survives unrelated accesses, single use of an arming, set-wins collisions, and the enable gating of fault detection, because each of these depends on an earlier status read.

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl #(
  parameter int ADDR_W      = 3,
  parameter int CTRL1_ADDR  = 0,
  parameter int STATUS_ADDR = 3,
  parameter int DATA_ADDR   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_byte_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_taken,
  output logic [7:0]        tx_byte,
  input  logic              ss_n,
  input  logic              master_en,
  input  logic              fault_det_en,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL1_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

  logic rx_full, tx_empty, mode_fault;
  logic rx_arm, tx_arm, mf_arm;
  logic [7:0] rx_data;

  wire rd_stat  = bus_sel & ~bus_wr & (bus_addr == A_STAT);
  wire rd_data  = bus_sel & ~bus_wr & (bus_addr == A_DATA);
  wire wr_data  = bus_sel &  bus_wr & (bus_addr == A_DATA);
  wire wr_ctrl  = bus_sel &  bus_wr & (bus_addr == A_CTRL);
  wire fault_now = master_en & fault_det_en & ~ss_n;

  wire rx_clr = rd_data & rx_arm;
  wire tx_clr = wr_data & tx_arm;
  wire mf_clr = wr_ctrl & mf_arm;

  always_comb begin
    bus_rdata = 8'h00;
    if (rd_stat)      bus_rdata = {rx_full, 1'b0, tx_empty, mode_fault, 4'h0};
    else if (rd_data) bus_rdata = rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full    <= 1'b0;
      tx_empty   <= 1'b1;
      mode_fault <= 1'b0;
      rx_arm     <= 1'b0;
      tx_arm     <= 1'b0;
      mf_arm     <= 1'b0;
      rx_data    <= 8'h00;
      tx_byte    <= 8'h00;
    end else begin
      if (rx_byte_valid) rx_full <= 1'b1;
      else if (rx_clr)   rx_full <= 1'b0;
      if (tx_taken)      tx_empty <= 1'b1;
      else if (tx_clr)   tx_empty <= 1'b0;
      if (fault_now)     mode_fault <= 1'b1;
      else if (mf_clr)   mode_fault <= 1'b0;

      if (rx_clr)                  rx_arm <= 1'b0;
      else if (rd_stat && rx_full) rx_arm <= 1'b1;
      if (tx_clr)                  tx_arm <= 1'b0;
      else if (rd_stat && tx_empty) tx_arm <= 1'b1;
      if (mf_clr)                  mf_arm <= 1'b0;
      else if (rd_stat && mode_fault) mf_arm <= 1'b1;

      if (rx_byte_valid) rx_data <= rx_byte;
      if (tx_clr)        tx_byte <= bus_wdata;
    end
  end

  assign irq = rx_full | tx_empty | mode_fault;
endmodule

module spi_flag_ctrl_chk #(
  parameter int ADDR_W      = 3,
  parameter int CTRL1_ADDR  = 0,
  parameter int STATUS_ADDR = 3,
  parameter int DATA_ADDR   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              rx_byte_valid,
  input logic              tx_taken,
  input logic [7:0]        tx_byte,
  input logic              ss_n,
  input logic              master_en,
  input logic              fault_det_en,
  input logic              rx_full,
  input logic              tx_empty,
  input logic              mode_fault,
  input logic              tx_arm
);
  wire s_rd = bus_sel && !bus_wr && bus_addr == ADDR_W'(STATUS_ADDR);
  wire d_rd = bus_sel && !bus_wr && bus_addr == ADDR_W'(DATA_ADDR);
  wire d_wr = bus_sel &&  bus_wr && bus_addr == ADDR_W'(DATA_ADDR);
  wire c_wr = bus_sel &&  bus_wr && bus_addr == ADDR_W'(CTRL1_ADDR);

  AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    s_rd |-> (bus_rdata & 8'h4F) == 8'h00);                               // R1
  AST_RX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_valid |=> rx_full);                                            // R3
  AST_RX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !d_rd) |=> rx_full);                                       // R4
  AST_TX_UNARMED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (d_wr && !tx_arm) |=> $stable(tx_byte));                               // R6
  AST_TX_TAKEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |=> tx_empty);                                                // R11
  AST_MF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && fault_det_en && !ss_n) |=> mode_fault);                  // R7
  AST_MF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fault && !c_wr) |=> mode_fault);                                 // R8
endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk #(
  .ADDR_W(ADDR_W), .CTRL1_ADDR(CTRL1_ADDR),
  .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .rx_byte_valid(rx_byte_valid),
  .tx_taken(tx_taken), .tx_byte(tx_byte), .ss_n(ss_n), .master_en(master_en),
  .fault_det_en(fault_det_en), .rx_full(rx_full), .tx_empty(tx_empty),
  .mode_fault(mode_fault), .tx_arm(tx_arm)
);

// File: tb/tb_spi_flag_ctrl.sv
module tb_spi_flag_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, rx_byte = 0;
  logic rx_byte_valid = 0, tx_taken = 0;
  logic ss_n = 1, master_en = 0, fault_det_en = 0;
  logic [7:0] bus_rdata, tx_byte;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_flag_ctrl dut (.*);

  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd3, A_DATA = 3'd5;
  // op: 1 status rd, 2 data rd, 3 data wr, 4 ctrl wr, 5 rx strobe, 6 tx taken, 7 status wr
  // fields: op[27:25] wdata[24:17] exp_rdata[16:9] exp_tx[8:1] exp_irq[0]
  localparam int NV = 15;
  localparam logic [27:0] VEC [NV] = '{
    {3'd1, 8'h00, 8'h20, 8'h00, 1'b1},
    {3'd3, 8'hA5, 8'h00, 8'hA5, 1'b0},
    {3'd3, 8'h3C, 8'h00, 8'hA5, 1'b0},  // arming used up once (R10)
    {3'd1, 8'h00, 8'h00, 8'hA5, 1'b0},
    {3'd3, 8'h11, 8'h00, 8'hA5, 1'b0},
    {3'd6, 8'h00, 8'h00, 8'hA5, 1'b1},
    {3'd5, 8'h5A, 8'h00, 8'hA5, 1'b1},
    {3'd2, 8'h00, 8'h5A, 8'hA5, 1'b1},
    {3'd1, 8'h00, 8'hA0, 8'hA5, 1'b1},
    {3'd4, 8'h00, 8'h00, 8'hA5, 1'b1},  // arming survives other access (R10)
    {3'd2, 8'h00, 8'h5A, 8'hA5, 1'b1},
    {3'd1, 8'h00, 8'h20, 8'hA5, 1'b1},
    {3'd3, 8'h77, 8'h00, 8'h77, 1'b0},
    {3'd7, 8'hFF, 8'h00, 8'h77, 1'b0},
    {3'd1, 8'h00, 8'h00, 8'h77, 1'b0}
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic sel, input logic wr, input logic [2:0] a,
                     input logic [7:0] wd, input logic rxv, input logic [7:0] rxb,
                     input logic txk, output logic [7:0] rd);
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rx_byte_valid = rxv; rx_byte = rxb; tx_taken = txk;
    #1 rd = bus_rdata;
    @(posedge clk);
    #1;
    bus_sel = 0; bus_wr = 0; rx_byte_valid = 0; tx_taken = 0;
  endtask

  task automatic stat(string tag, logic [7:0] exp);
    logic [7:0] r;
    cyc(1, 0, A_STAT, 0, 0, 0, 0, r);
    check(tag, r, exp);
  endtask

  task automatic run_op(logic [2:0] op, logic [7:0] wd, output logic [7:0] r);
    case (op)
      3'd1: cyc(1, 0, A_STAT, 0, 0, 0, 0, r);
      3'd2: cyc(1, 0, A_DATA, 0, 0, 0, 0, r);
      3'd3: cyc(1, 1, A_DATA, wd, 0, 0, 0, r);
      3'd4: cyc(1, 1, A_CTRL, wd, 0, 0, 0, r);
      3'd5: cyc(0, 0, A_STAT, 0, 1, wd, 0, r);
      3'd6: cyc(0, 0, A_STAT, 0, 0, 0, 1, r);
      3'd7: cyc(1, 1, A_STAT, wd, 0, 0, 0, r);
      default: cyc(0, 0, A_STAT, 0, 0, 0, 0, r);
    endcase
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9 reset state
    check("R9 tx_byte", tx_byte, 8'h00);
    check("R9 irq", {7'd0, irq}, 8'h01);
    stat("R9 R1 status", 8'h20);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      op = VEC[i][27:25];
      run_op(op, VEC[i][24:17], r);
      if (op == 3'd1) check($sformatf("R1 vec%0d status", i), r, VEC[i][16:9]);
      if (op == 3'd2) check($sformatf("R3 R4 vec%0d data", i), r, VEC[i][16:9]);
      check($sformatf("R5 R6 R2 vec%0d tx_byte", i), tx_byte, VEC[i][8:1]);
      check($sformatf("R12 R4 R10 vec%0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
    end

    // R7 enable gating: fault detect off -> no set
    master_en = 1; fault_det_en = 0; ss_n = 0;
    repeat (2) @(posedge clk);
    #1 check("R7 gated irq", {7'd0, irq}, 8'h00);
    fault_det_en = 1;
    @(posedge clk); #1;
    ss_n = 1; master_en = 0;
    check("R7 set irq", {7'd0, irq}, 8'h01);
    cyc(1, 1, A_CTRL, 8'h00, 0, 0, 0, r);
    check("R8 unarmed ctrl write", {7'd0, irq}, 8'h01);
    stat("R7 R1 status", 8'h10);
    cyc(1, 0, A_DATA, 0, 0, 0, 0, r);
    check("R8 R10 arm survives data read", {7'd0, irq}, 8'h01);
    cyc(1, 1, A_CTRL, 8'h00, 0, 0, 0, r);
    check("R8 armed clear irq", {7'd0, irq}, 8'h00);

    // R11 tx set wins over armed write; byte still accepted
    cyc(0, 0, A_STAT, 0, 0, 0, 1, r);
    stat("R11 status", 8'h20);
    cyc(1, 1, A_DATA, 8'h99, 0, 0, 1, r);
    check("R11 tx_byte", tx_byte, 8'h99);
    stat("R11 set wins", 8'h20);

    // R11 rx set wins over armed data read
    cyc(0, 0, A_STAT, 0, 1, 8'hC3, 0, r);
    stat("R3 status", 8'hA0);
    cyc(1, 0, A_DATA, 0, 1, 8'h3E, 0, r);
    check("R3 data", r, 8'hC3);
    stat("R11 rx set wins", 8'hA0);
    cyc(1, 0, A_DATA, 0, 0, 0, 0, r);
    check("R3 new data", r, 8'h3E);
    stat("R4 rx cleared", 8'h20);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule